// File: doc/BRIEF.md
# Imbalanced Way-Partition Controller

This controller decides how the 32 ways of a shared last-level cache are divided among four cores that all run the same data-parallel program. It does not split the ways fairly. It favours one preferred core with a large share, and it rotates which core is preferred so that every core still makes balanced progress.

A phase-change pulse starts an evaluation stage. During evaluation the cache sets are split into five groups by set index. One group stays unpartitioned. Each of the other four groups tries a different degree of skew. The preferred core moves to the next core after every window of valid accesses. Each group has a saturating miss counter that accumulates over all four windows. When the last window closes, the configuration whose group recorded the fewest misses is applied to every set. This is the stable stage, and it lasts until the next pulse. In the stable stage the preferred core advances round-robin after a fixed number of valid accesses.

The cache looks up the allowed-way masks of the set it is about to fill through a query port. The masks are combinational from that port.

Top module: `imb_part_ctrl`

## Requirements
- R1: After reset the block is in the stable stage with the unpartitioned configuration. Every core's mask is all ones and `eval_busy_o` is 0.
- R2: A `phase_chg_i` pulse raises `eval_busy_o` from the next cycle. It clears all miss counters and makes core 0 preferred. A pulse that arrives during evaluation restarts the evaluation from the beginning.
- R3: During evaluation, set s belongs to group g = s mod 5. Group 0 gives every core all 32 ways. Groups 1, 2, 3 and 4 give the preferred core 8, 14, 20 and 26 ways.
- R4: In a partitioned configuration the preferred core owns ways 0 up to P-1. The remaining ways are split evenly among the other cores in ascending core order, each core getting a contiguous run. The masks are disjoint and together cover all 32 ways. Core c's mask is `way_mask_o[c*32 +: 32]`.
- R5: During evaluation the preferred core starts at 0 and advances by one after every EVAL_N valid accesses. After four windows the evaluation ends.
- R6: Each group keeps a CNT_W-bit miss counter. The counter increments on a valid access with `acc_miss_i` high that falls in its group. It saturates at its maximum value and never wraps.
- R7: At the end of evaluation the configuration of the group with the smallest count is chosen. On a tie the lower group number wins, so group 0 (unpartitioned) beats any other group.
- R8: Two cycles after the last evaluation access, `eval_busy_o` falls. From then on every set uses the chosen configuration, and core 0 is preferred. The configuration then holds until the next pulse.
- R9: In the stable stage the preferred core advances by one, wrapping from 3 to 0, after every ROT_M valid accesses. Cycles with `acc_valid_i` low do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_chg_i | input | 1 | Program phase change pulse |
| acc_valid_i | input | 1 | A cache access is reported this cycle |
| acc_set_i | input | SET_W | Set index of the reported access |
| acc_miss_i | input | 1 | The reported access missed |
| qry_set_i | input | SET_W | Set whose way masks are requested |
| way_mask_o | output | 4*32 | Allowed-way masks, core c at bits c*32 +: 32 |
| eval_busy_o | output | 1 | Evaluation or selection under way |

## Verification
On every cycle the assertions check the following:
- Partitioned masks are disjoint and cover all ways.
- In the stable stage the preferred core's share matches the chosen level.
- A pulse always starts evaluation.
- The chosen configuration stays fixed in the stable stage.
- Saturated counters stay at their maximum.
- Each stable rotation advances the preferred core by one.

Only the bench scenarios can show the following:
- The group mapping by set index.
- Window-by-window rotation during evaluation.
- Which configuration wins under given miss patterns, including ties, saturation and a restarted evaluation.

// File: rtl/imb_pkg.sv
package imb_pkg;
  localparam int NCORE     = 4;
  localparam int NWAY      = 32;
  localparam int NSEG      = 5;
  localparam int CORE_W    = 2;
  localparam int SEG_W     = 3;
  localparam int LVL_BASE  = 8;
  localparam int LVL_STEP  = 6;

  typedef enum logic [1:0] {ST_STABLE, ST_EVAL, ST_PICK} ctl_state_t;

  // ways granted to the preferred core for a partitioned configuration 1..4
  function automatic int pref_share(input logic [SEG_W-1:0] cfg);
    return LVL_BASE + LVL_STEP * (int'(cfg) - 1);
  endfunction

  function automatic logic [NWAY-1:0] span_mask(input int lo, input int len);
    logic [NWAY-1:0] m;
    m = '0;
    for (int w = 0; w < NWAY; w++) begin
      if (w >= lo && w < lo + len) m[w] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [NWAY-1:0] core_ways(input logic [SEG_W-1:0] cfg,
                                                input logic [CORE_W-1:0] pref,
                                                input logic [CORE_W-1:0] core);
    int p, rest, q, rem, rank, lo, len;
    if (cfg == '0) return '1;
    p    = pref_share(cfg);
    rest = NWAY - p;
    q    = rest / (NCORE - 1);
    rem  = rest % (NCORE - 1);
    if (core == pref) return span_mask(0, p);
    rank = (core < pref) ? int'(core) : int'(core) - 1;
    lo   = p + rank * q + ((rank < rem) ? rank : rem);
    len  = q + ((rank < rem) ? 1 : 0);
    return span_mask(lo, len);
  endfunction
endpackage

// File: rtl/imb_seg_map.sv
module imb_seg_map
  import imb_pkg::*;
#(
  parameter int SET_W = 10
) (
  input  logic [SET_W-1:0] set_i,
  output logic [SEG_W-1:0] seg_o
);
  localparam logic [SET_W-1:0] DIV = SET_W'(NSEG);
  logic [SET_W-1:0] rem_w;
  assign rem_w = set_i % DIV;
  assign seg_o = rem_w[SEG_W-1:0];
endmodule

// File: rtl/imb_miss_bank.sv
module imb_miss_bank
  import imb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       inc_i,
  input  logic [SEG_W-1:0]           seg_i,
  output logic [NSEG-1:0][CNT_W-1:0] cnt_o,
  output logic [SEG_W-1:0]           best_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < NSEG; g++) begin : g_cnt
    logic hit;
    assign hit = inc_i && (seg_i == SEG_W'(g)) && (cnt_o[g] != CNT_MAX);
    always_ff @(posedge clk) begin
      if (!rst_n)    cnt_o[g] <= '0;
      else if (clr_i) cnt_o[g] <= '0;
      else if (hit)   cnt_o[g] <= cnt_o[g] + 1'b1;
    end
  end

  // strict less-than keeps the lowest index on ties
  always_comb begin
    logic [CNT_W-1:0] bv;
    best_o = '0;
    bv     = cnt_o[0];
    for (int s = 1; s < NSEG; s++) begin
      if (cnt_o[s] < bv) begin
        best_o = SEG_W'(s);
        bv     = cnt_o[s];
      end
    end
  end
endmodule

// File: rtl/imb_mask_gen.sv
module imb_mask_gen
  import imb_pkg::*;
(
  input  logic [SEG_W-1:0]      cfg_i,
  input  logic [CORE_W-1:0]     pref_i,
  output logic [NCORE*NWAY-1:0] mask_o
);
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assign mask_o[c*NWAY +: NWAY] = core_ways(cfg_i, pref_i, CORE_W'(c));
  end
endmodule

// File: rtl/imb_part_ctrl.sv
module imb_part_ctrl
  import imb_pkg::*;
#(
  parameter int SET_W  = 10,
  parameter int EVAL_N = 64,
  parameter int ROT_M  = 256,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  phase_chg_i,
  input  logic                  acc_valid_i,
  input  logic [SET_W-1:0]      acc_set_i,
  input  logic                  acc_miss_i,
  input  logic [SET_W-1:0]      qry_set_i,
  output logic [NCORE*NWAY-1:0] way_mask_o,
  output logic                  eval_busy_o
);
  localparam int ACC_W = (EVAL_N > 1) ? $clog2(EVAL_N) : 1;
  localparam int ROT_W = (ROT_M > 1) ? $clog2(ROT_M) : 1;
  localparam logic [ACC_W-1:0]  ACC_LAST  = ACC_W'(EVAL_N - 1);
  localparam logic [ROT_W-1:0]  ROT_LAST  = ROT_W'(ROT_M - 1);
  localparam logic [CORE_W-1:0] LAST_CORE = CORE_W'(NCORE - 1);

  ctl_state_t        state_q;
  logic [SEG_W-1:0]  cfg_q;
  logic [CORE_W-1:0] pref_q;
  logic [ACC_W-1:0]  acc_cnt_q;
  logic [ROT_W-1:0]  rot_cnt_q;

  // named events for the checker
  logic eval_start, turn_end, pick_fire, rot_fire, miss_inc, state_stable;
  logic [SEG_W-1:0] acc_seg, qry_seg, best_cfg, mask_cfg;
  logic [NSEG-1:0][CNT_W-1:0] miss_cnt;

  assign eval_start   = phase_chg_i;
  assign turn_end     = !eval_start && (state_q == ST_EVAL) && acc_valid_i &&
                        (acc_cnt_q == ACC_LAST);
  assign pick_fire    = !eval_start && (state_q == ST_PICK);
  assign rot_fire     = !eval_start && (state_q == ST_STABLE) && acc_valid_i &&
                        (rot_cnt_q == ROT_LAST);
  assign miss_inc     = (state_q == ST_EVAL) && acc_valid_i && acc_miss_i;
  assign state_stable = (state_q == ST_STABLE);

  imb_seg_map #(.SET_W(SET_W)) u_acc_map (.set_i(acc_set_i), .seg_o(acc_seg));
  imb_seg_map #(.SET_W(SET_W)) u_qry_map (.set_i(qry_set_i), .seg_o(qry_seg));

  imb_miss_bank #(.CNT_W(CNT_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (eval_start),
    .inc_i  (miss_inc),
    .seg_i  (acc_seg),
    .cnt_o  (miss_cnt),
    .best_o (best_cfg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_STABLE;
      cfg_q     <= '0;
      pref_q    <= '0;
      acc_cnt_q <= '0;
      rot_cnt_q <= '0;
    end else if (eval_start) begin
      state_q   <= ST_EVAL;
      pref_q    <= '0;
      acc_cnt_q <= '0;
      rot_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_EVAL: begin
          if (acc_valid_i) begin
            if (turn_end) begin
              acc_cnt_q <= '0;
              if (pref_q == LAST_CORE) state_q <= ST_PICK;
              else                     pref_q  <= pref_q + 1'b1;
            end else begin
              acc_cnt_q <= acc_cnt_q + 1'b1;
            end
          end
        end
        ST_PICK: begin
          cfg_q     <= best_cfg;
          pref_q    <= '0;
          rot_cnt_q <= '0;
          state_q   <= ST_STABLE;
        end
        default: begin
          if (acc_valid_i) begin
            if (rot_fire) begin
              rot_cnt_q <= '0;
              pref_q    <= pref_q + 1'b1;
            end else begin
              rot_cnt_q <= rot_cnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign mask_cfg = (state_q == ST_EVAL) ? qry_seg : cfg_q;

  imb_mask_gen u_masks (
    .cfg_i  (mask_cfg),
    .pref_i (pref_q),
    .mask_o (way_mask_o)
  );

  assign eval_busy_o = !state_stable;
endmodule

// File: rtl/imb_part_ctrl_chk.sv
module imb_part_ctrl_chk
  import imb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       phase_chg_i,
  input logic [NCORE*NWAY-1:0]      way_mask_o,
  input logic                       eval_busy_o,
  input logic                       state_stable,
  input logic [SEG_W-1:0]           cfg_q,
  input logic [CORE_W-1:0]          pref_q,
  input logic                       rot_fire,
  input logic [NSEG-1:0][CNT_W-1:0] miss_cnt
);
  logic [NWAY-1:0] m0, m1, m2, m3;
  assign m0 = way_mask_o[0*NWAY +: NWAY];
  assign m1 = way_mask_o[1*NWAY +: NWAY];
  assign m2 = way_mask_o[2*NWAY +: NWAY];
  assign m3 = way_mask_o[3*NWAY +: NWAY];

  // R2: a pulse always leads to evaluation
  assert_eval_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_chg_i |=> eval_busy_o);

  // R4: partitioned masks are disjoint and cover every way
  assert_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m0 != '1) |-> (((m0 & m1) | (m0 & m2) | (m0 & m3) | (m1 & m2) | (m1 & m3) |
                     (m2 & m3)) == '0) && ((m0 | m1 | m2 | m3) == '1));

  // R3 / R8: preferred share in the stable stage follows the chosen level
  assert_pref_share_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_stable && cfg_q != '0) |->
      ($countones(way_mask_o[pref_q*NWAY +: NWAY]) == LVL_BASE + LVL_STEP * (int'(cfg_q) - 1)));

  // R8: the choice holds while stable
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_stable && !phase_chg_i) |=> $stable(cfg_q));

  // R9: each rotation moves to the next core
  assert_rotate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rot_fire |=> (pref_q == $past(pref_q) + 1'b1));

  // R6: saturated counters stay saturated
  for (genvar g = 0; g < NSEG; g++) begin : g_sat
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_cnt[g] == '1 && !phase_chg_i) |=> (miss_cnt[g] == '1));
  end
endmodule

bind imb_part_ctrl imb_part_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .phase_chg_i  (phase_chg_i),
  .way_mask_o   (way_mask_o),
  .eval_busy_o  (eval_busy_o),
  .state_stable (state_stable),
  .cfg_q        (cfg_q),
  .pref_q       (pref_q),
  .rot_fire     (rot_fire),
  .miss_cnt     (miss_cnt)
);

// File: tb/imb_part_ctrl_tb.sv
`timescale 1ns/1ps
module imb_part_ctrl_tb_top;
  localparam int SET_W  = 8;
  localparam int EVAL_N = 40;
  localparam int ROT_M  = 6;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_chg_i = 1'b0;
  logic acc_valid_i = 1'b0;
  logic [SET_W-1:0] acc_set_i = '0;
  logic acc_miss_i = 1'b0;
  logic [SET_W-1:0] qry_set_i = '0;
  logic [127:0] way_mask_o;
  logic eval_busy_o;

  int n_tests = 0;
  int n_fail  = 0;
  int lim[5];
  int used[5];

  always #4 clk = ~clk;

  imb_part_ctrl #(.SET_W(SET_W), .EVAL_N(EVAL_N), .ROT_M(ROT_M), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .phase_chg_i(phase_chg_i), .acc_valid_i(acc_valid_i),
    .acc_set_i(acc_set_i), .acc_miss_i(acc_miss_i), .qry_set_i(qry_set_i),
    .way_mask_o(way_mask_o), .eval_busy_o(eval_busy_o));

  // {set, configuration expected in evaluation}
  localparam logic [15:0] VEC [8] = '{
    {8'd0, 8'd0}, {8'd6, 8'd1}, {8'd12, 8'd2}, {8'd18, 8'd3},
    {8'd24, 8'd4}, {8'd255, 8'd0}, {8'd254, 8'd4}, {8'd128, 8'd3}};

  // independent model: walk the cores, handing out runs from a moving offset
  function automatic logic [127:0] model(int cfg, int pref);
    logic [127:0] r;
    logic [63:0] run;
    int p, each, off;
    if (cfg == 0) return '1;
    p = 2 + 6 * cfg;
    each = (32 - p) / 3;
    off = p;
    r = '0;
    for (int c = 0; c < 4; c++) begin
      if (c == pref) begin
        run = (64'd1 << p) - 64'd1;
      end else begin
        run = ((64'd1 << each) - 64'd1) << off;
        off += each;
      end
      r[c*32 +: 32] = run[31:0];
    end
    return r;
  endfunction

  task automatic check_set(input int set, input int cfg, input int pref, input string tag);
    logic [127:0] e;
    qry_set_i = SET_W'(set);
    #1;
    e = model(cfg, pref);
    n_tests++;
    if (way_mask_o !== e) begin
      n_fail++;
      $display("FAIL %s set=%0d actual=%h expected=%h", tag, set, way_mask_o, e);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) phase_chg_i = 1'b1;
    @(negedge clk) phase_chg_i = 1'b0;
  endtask

  task automatic access(input int set, input logic miss);
    @(negedge clk);
    acc_valid_i = 1'b1;
    acc_set_i   = SET_W'(set);
    acc_miss_i  = miss;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid_i = 1'b0;
    acc_miss_i  = 1'b0;
  endtask

  task automatic run_eval(input bit chk_turn);
    for (int s = 0; s < 5; s++) used[s] = 0;
    for (int i = 0; i < 4 * EVAL_N; i++) begin
      int sg;
      sg = i % 5;
      @(negedge clk);
      if (chk_turn && i == EVAL_N) check_set(12, 2, 1, "R5 second window prefers core 1");
      acc_valid_i = 1'b1;
      acc_set_i   = SET_W'(sg + 5 * (i % 40));
      acc_miss_i  = (used[sg] < lim[sg]);
      if (used[sg] < lim[sg]) used[sg]++;
    end
    idle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_bit(eval_busy_o, 1'b0, "R1 busy after reset");
    check_set(0, 0, 0, "R1 set 0 all ones");
    check_set(13, 0, 0, "R1 set 13 all ones");

    // R2 / R3 / R4: evaluation, table walk with core 0 preferred
    pulse();
    check_bit(eval_busy_o, 1'b1, "R2 busy after pulse");
    for (int k = 0; k < 8; k++)
      check_set(int'(VEC[k][15:8]), int'(VEC[k][7:0]), 0, "R3 R4 group mapping");

    lim = '{15, 15, 15, 0, 15};
    run_eval(1'b1);
    check_bit(eval_busy_o, 1'b0, "R8 busy low after choice");
    check_set(0, 3, 0, "R7 R8 group 3 chosen, set 0");
    check_set(7, 3, 0, "R8 set 7 uses chosen config");

    // R9 rotation in stable stage
    for (int i = 0; i < ROT_M - 1; i++) access(i, 1'b1);
    idle();
    check_set(1, 3, 0, "R9 no rotation before ROT_M");
    access(2, 1'b0);
    idle();
    check_set(1, 3, 1, "R9 rotates to core 1");
    repeat (10) idle();
    check_set(1, 3, 1, "R9 idle cycles do not rotate");
    for (int i = 0; i < 3 * ROT_M; i++) access(i, 1'b0);
    idle();
    check_set(4, 3, 0, "R9 wraps 3 to 0");

    // R2 restart clears counters
    pulse();
    for (int i = 0; i < 20; i++) access(3, 1'b1);
    idle();
    pulse();
    check_set(6, 1, 0, "R2 restart prefers core 0");
    lim = '{9, 9, 2, 9, 9};
    run_eval(1'b0);
    check_set(5, 2, 0, "R2 R7 restart clears counts, group 2");

    // R7 all zero tie -> unpartitioned
    pulse();
    lim = '{0, 0, 0, 0, 0};
    run_eval(1'b0);
    check_set(9, 0, 0, "R7 full tie picks unpartitioned");

    // R7 tie between groups 3 and 4
    pulse();
    lim = '{5, 5, 5, 0, 0};
    run_eval(1'b0);
    check_set(9, 3, 0, "R7 tie picks lower group");

    // R7 strict minimum
    pulse();
    lim = '{5, 3, 7, 9, 4};
    run_eval(1'b0);
    check_set(2, 1, 0, "R7 minimum picks group 1");

    // R6 saturation: 16 misses must not wrap to zero
    pulse();
    lim = '{20, 16, 32, 32, 32};
    run_eval(1'b0);
    check_set(2, 0, 0, "R6 saturated counts tie to unpartitioned");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule